// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a small sum-of-products programmable logic device. It takes the product-term lines assigned to the cell, an output-enable product term, and two shared asynchronous terms that force the cell's flip-flop to 1 or 0. It turns these into a three-state pin model, given as a driven value and a drive enable, and a feedback bit that returns to the AND plane.

Two configuration bits set the behaviour. A mode bit chooses between a registered output, where an edge-triggered flip-flop captures the OR-sum and its state is fed back, and a combinational I/O, where the OR-sum goes straight to the pin and the feedback is taken from the pin itself. A polarity bit chooses active-high or active-low output. The all-zero configuration, the state of an unprogrammed cell, is registered active-low. A test preload path writes any value into the flip-flop on a clock edge, whatever the product terms say, so that a state sequence can be started from any state.

The force-to-1 and force-to-0 terms act on the flip-flop and not on the pin, so the level seen at the pin depends on the polarity bit. A cell whose enable term is held low drives nothing and works as a dedicated input through its feedback.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst_n` is low, each rising clock edge clears the flip-flop to 0. This takes priority over preload and over the product terms, but not over `preset_term`.
- R2: In registered mode (`cfg_comb` = 0), when `preload_en`, `preset_term` and `reset_term` are all low, each rising edge loads the OR of all `pterm` bits into the flip-flop. `pin_val` then equals the flip-flop for `cfg_pol_high` = 1 and its complement for `cfg_pol_high` = 0.
- R3: In combinational mode (`cfg_comb` = 1), `pin_val` equals the OR of `pterm` (for `cfg_pol_high` = 1) or its complement (for `cfg_pol_high` = 0) in the same cycle, with no clock edge. The flip-flop state and `preset_term` have no effect on `pin_val` in this mode.
- R4: `pin_oe` is 1 exactly when `oe_term` is 1, in both modes.
- R5: In registered mode `fb` equals the flip-flop state, whatever `pin_in`, `oe_term` and the polarity bit are.
- R6: Raising `preset_term` sets the flip-flop to 1 at once, without a clock edge. A registered active-high pin then reads 1 and an active-low pin reads 0. The flip-flop holds 1 after the term falls, until the next clock edge.
- R7: Raising `reset_term` clears the flip-flop to 0 at once, without a clock edge. When both asynchronous terms are high, the flip-flop is 0.
- R8: A rising edge with `preload_en` = 1 (and `rst_n` high, no asynchronous term) loads `preload_data` into the flip-flop, ignoring `pterm`. The next edge without preload resumes normal capture.
- R9: The configuration encoding is `cfg_comb` 0 = registered, 1 = combinational, and `cfg_pol_high` 0 = active-low, 1 = active-high. With both bits 0 after reset, the pin reads 1 (the complement of a cleared flip-flop).
- R10: In combinational mode `fb` equals `pin_in`. With `oe_term` low the cell drives nothing (`pin_oe` = 0) and `fb` follows the externally driven pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flip-flop |
| rst_n | input | 1 | Synchronous active-low power-up clear |
| cfg_comb | input | 1 | Mode: 0 registered, 1 combinational I/O |
| cfg_pol_high | input | 1 | Polarity: 0 active-low, 1 active-high |
| pterm | input | N_TERMS | Product-term lines ORed into this cell |
| oe_term | input | 1 | Output-enable product term (1 drives the pin) |
| preset_term | input | 1 | Shared asynchronous force-to-1 term |
| reset_term | input | 1 | Shared asynchronous force-to-0 term, wins over preset |
| preload_en | input | 1 | Test preload request, taken on the next edge |
| preload_data | input | 1 | Value written by preload |
| pin_in | input | 1 | Resolved level present on the pin |
| pin_val | output | 1 | Value the cell drives onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback bit to the AND plane |

## Verification
The assertions check on every cycle that the flip-flop captures the OR-sum or the preload value one edge later, that it stays cleared while the force-to-0 term is high, and that a forced-to-1 register reads at the pin according to polarity. They also check that the feedback in each mode agrees with the pin or the register, and that the combinational pin follows the OR-sum. The bench scenarios cover what sampled properties cannot: the immediate, edge-free response to the asynchronous terms, the register keeping its forced value after the term falls, polarity being switched while a force is held, and the sequence of a preload followed by normal clocking.

// File: rtl/pld_mc_pkg.sv
// Package: shared types and helpers for the output macrocell.
// Assumes: configuration bits are static or change only between checks.
package pld_mc_pkg;

    // Operating mode chosen by the mode configuration bit.
    typedef enum logic {
        MODE_REG  = 1'b0,
        MODE_COMB = 1'b1
    } cell_mode_e;

    // Output polarity chosen by the polarity configuration bit.
    typedef enum logic {
        POL_LOW  = 1'b0,
        POL_HIGH = 1'b1
    } cell_pol_e;

    // Apply output polarity to an internal logic value.
    function automatic logic apply_pol(input logic value, input cell_pol_e pol);
        return (pol == POL_HIGH) ? value : ~value;
    endfunction

endpackage

// File: rtl/mc_or_plane.sv
// Module: mc_or_plane
// Purpose: OR-sums the product-term lines of one cell in two levels
// (groups of GROUP lines, then across groups) to bound gate fan-in.
// Assumes: unused lines are driven 0 by the AND plane.
module mc_or_plane #(
    parameter int N_TERMS = 8,
    parameter int GROUP   = 4
) (
    input  logic [N_TERMS-1:0] terms,
    output logic               sum
);

    localparam int N_GROUPS = (N_TERMS + GROUP - 1) / GROUP;
    localparam int PADDED   = N_GROUPS * GROUP;

    logic [PADDED-1:0]   padded;
    logic [N_GROUPS-1:0] grp_or;

    // Zero-extend the term vector to a whole number of groups.
    always_comb begin
        padded = '0;
        padded[N_TERMS-1:0] = terms;
    end

    // First level: one OR gate per group of lines.
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        assign grp_or[g] = |padded[g*GROUP +: GROUP];
    end

    // Second level: combine the group results.
    assign sum = |grp_or;

endmodule

// File: rtl/mc_state_reg.sv
// Module: mc_state_reg
// Purpose: the cell's edge-triggered D flip-flop. It has asynchronous
// force-to-0 and force-to-1 inputs (force-to-0 wins), a synchronous
// active-low power-up clear, and a test preload that overrides D.
// Assumes: an asynchronous force is held across at least one clock edge.
module mc_state_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_async,
    input  logic set_async,
    input  logic preload_en,
    input  logic preload_data,
    input  logic d,
    output logic q
);

    // State update: async forces, then sync clear, then preload, then D.
    always_ff @(posedge clk or posedge clr_async or posedge set_async) begin
        if (clr_async) begin
            q <= 1'b0;
        end else if (set_async) begin
            q <= 1'b1;
        end else if (!rst_n) begin
            q <= 1'b0;
        end else if (preload_en) begin
            q <= preload_data;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/mc_out_path.sv
// Module: mc_out_path
// Purpose: output-select mux (register or OR-sum), polarity stage and
// the three-state pin model (value plus enable).
// Assumes: the enable term drives the pin when high.
module mc_out_path
    import pld_mc_pkg::*;
(
    input  cell_mode_e mode,
    input  cell_pol_e  pol,
    input  logic       sum,
    input  logic       q,
    input  logic       oe_term,
    output logic       pin_val,
    output logic       pin_oe
);

    logic core;

    // Output-select mux: register state or the OR-sum.
    always_comb begin
        core = (mode == MODE_COMB) ? sum : q;
    end

    // Polarity stage and driver enable.
    always_comb begin
        pin_val = apply_pol(core, pol);
        pin_oe  = oe_term;
    end

endmodule

// File: rtl/mc_fb_sel.sv
// Module: mc_fb_sel
// Purpose: feedback-select mux to the AND plane. It returns the register
// state in registered mode and the resolved pin level in combinational mode.
// Assumes: pin_in is the level on the pin after three-state resolution.
module mc_fb_sel
    import pld_mc_pkg::*;
(
    input  cell_mode_e mode,
    input  logic       q,
    input  logic       pin_in,
    output logic       fb
);

    // Feedback source selection.
    always_comb begin
        fb = (mode == MODE_REG) ? q : pin_in;
    end

endmodule

// File: rtl/pld_macrocell.sv
// Module: pld_macrocell (top)
// Purpose: one configurable output cell of a sum-of-products device. It
// combines the OR plane, flip-flop, output path and feedback mux.
// Assumes: preset_term/reset_term are shared by all cells and active high.
// The all-zero configuration is registered, active-low.
module pld_macrocell
    import pld_mc_pkg::*;
#(
    parameter int N_TERMS  = 8,
    parameter int OR_GROUP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_comb,
    input  logic               cfg_pol_high,
    input  logic [N_TERMS-1:0] pterm,
    input  logic               oe_term,
    input  logic               preset_term,
    input  logic               reset_term,
    input  logic               preload_en,
    input  logic               preload_data,
    input  logic               pin_in,
    output logic               pin_val,
    output logic               pin_oe,
    output logic               fb
);

    cell_mode_e mode;
    cell_pol_e  pol;
    logic       or_sum;
    logic       q_state;

    // Decode the configuration bits into typed controls.
    always_comb begin
        mode = cell_mode_e'(cfg_comb);
        pol  = cell_pol_e'(cfg_pol_high);
    end

    mc_or_plane #(
        .N_TERMS (N_TERMS),
        .GROUP   (OR_GROUP)
    ) u_or (
        .terms (pterm),
        .sum   (or_sum)
    );

    mc_state_reg u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_async    (reset_term),
        .set_async    (preset_term),
        .preload_en   (preload_en),
        .preload_data (preload_data),
        .d            (or_sum),
        .q            (q_state)
    );

    mc_out_path u_out (
        .mode    (mode),
        .pol     (pol),
        .sum     (or_sum),
        .q       (q_state),
        .oe_term (oe_term),
        .pin_val (pin_val),
        .pin_oe  (pin_oe)
    );

    mc_fb_sel u_fb (
        .mode   (mode),
        .q      (q_state),
        .pin_in (pin_in),
        .fb     (fb)
    );

endmodule

// File: rtl/pld_macrocell_chk.sv
// Module: pld_macrocell_chk
// Purpose: concurrent checks on the macrocell, bound to every instance.
// Assumes: q_state is the top's flip-flop output, reached through bind.
module pld_macrocell_chk #(
    parameter int N_TERMS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_comb,
    input logic               cfg_pol_high,
    input logic [N_TERMS-1:0] pterm,
    input logic               preset_term,
    input logic               reset_term,
    input logic               preload_en,
    input logic               preload_data,
    input logic               pin_in,
    input logic               pin_val,
    input logic               fb,
    input logic               q_state
);

    // R1
    por_clear_chk: assert property (@(posedge clk)
        (!rst_n && !preset_term && !reset_term) |=> (preset_term || q_state == 1'b0));

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preload_en && !preset_term && !reset_term)
        |=> (preset_term || reset_term || q_state == $past(|pterm)));

    // R8
    preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !preset_term && !reset_term)
        |=> (preset_term || reset_term || q_state == $past(preload_data)));

    // R7
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_term |-> (q_state == 1'b0));

    // R6
    set_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_term && !reset_term && !cfg_comb) |-> (pin_val == cfg_pol_high));

    // R5
    fb_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_comb |-> (fb == (cfg_pol_high ? pin_val : !pin_val)));

    // R10
    fb_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_comb |-> (fb == pin_in));

    // R3
    comb_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_comb |-> (pin_val == (cfg_pol_high ? (|pterm) : !(|pterm))));

endmodule

bind pld_macrocell pld_macrocell_chk #(.N_TERMS(N_TERMS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_comb     (cfg_comb),
    .cfg_pol_high (cfg_pol_high),
    .pterm        (pterm),
    .preset_term  (preset_term),
    .reset_term   (reset_term),
    .preload_en   (preload_en),
    .preload_data (preload_data),
    .pin_in       (pin_in),
    .pin_val      (pin_val),
    .fb           (fb),
    .q_state      (q_state)
);

// File: tb/tb_pld_macrocell.sv
`timescale 1ns/1ps
// Bench for pld_macrocell: a vector table walked by one loop, then
// directed tests for reset, asynchronous forces, preload and input use.
module tb_pld_macrocell;

    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_comb = 1'b0;
    logic          cfg_pol_high = 1'b0;
    logic [NT-1:0] pterm = '0;
    logic          oe_term = 1'b0;
    logic          preset_term = 1'b0;
    logic          reset_term = 1'b0;
    logic          preload_en = 1'b0;
    logic          preload_data = 1'b0;
    logic          ext_drive = 1'b0;
    logic          pin_in;
    logic          pin_val;
    logic          pin_oe;
    logic          fb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    // Pin resolution: the cell drives when enabled, else the outside does.
    assign pin_in = pin_oe ? pin_val : ext_drive;

    pld_macrocell #(.N_TERMS(NT), .OR_GROUP(4)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_comb     (cfg_comb),
        .cfg_pol_high (cfg_pol_high),
        .pterm        (pterm),
        .oe_term      (oe_term),
        .preset_term  (preset_term),
        .reset_term   (reset_term),
        .preload_en   (preload_en),
        .preload_data (preload_data),
        .pin_in       (pin_in),
        .pin_val      (pin_val),
        .pin_oe       (pin_oe),
        .fb           (fb)
    );

    // Row: {comb, pol_high, pterm[7:0], oe, ext, exp_val, exp_oe, exp_fb, pad}
    localparam logic [15:0] VECS [12] = '{
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'h10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {1'b0, 1'b1, 8'h01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'h80, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'h80, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b1, 8'h0F, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    // Compare one bit and count the result.
    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    // Print the one summary line and stop.
    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 / R9: reset with the all-zero configuration.
        repeat (2) @(posedge clk);
        #1;
        check(pin_val, 1'b1, "R9", "unprogrammed pin after reset");
        check(pin_oe, 1'b0, "R4", "enable low after reset");
        check(fb, 1'b0, "R1", "register cleared by reset");
        @(negedge clk) rst_n = 1'b1;

        // Table walk: drive at the falling edge, check after the next rise.
        for (int i = 0; i < 12; i++) begin
            logic [15:0] v;
            v = VECS[i];
            @(negedge clk);
            cfg_comb     = v[15];
            cfg_pol_high = v[14];
            pterm        = v[13:6];
            oe_term      = v[5];
            ext_drive    = v[4];
            @(posedge clk);
            #1;
            check(pin_val, v[3], v[15] ? "R3" : "R2", $sformatf("row %0d pin value", i));
            check(pin_oe, v[2], "R4", $sformatf("row %0d enable", i));
            check(fb, v[1], v[15] ? "R10" : "R5", $sformatf("row %0d feedback", i));
        end

        // R6: preset acts at once, with no clock edge.
        @(negedge clk);
        cfg_comb = 1'b0; cfg_pol_high = 1'b1; pterm = '0; oe_term = 1'b1;
        @(posedge clk); #1;
        check(pin_val, 1'b0, "R2", "cleared before preset");
        @(negedge clk) preset_term = 1'b1;
        #1 check(pin_val, 1'b1, "R6", "preset, active-high pin");
        cfg_pol_high = 1'b0;
        #0.2 check(pin_val, 1'b0, "R6", "preset, active-low pin");
        @(posedge clk); #1;
        @(negedge clk) preset_term = 1'b0;
        #1 check(fb, 1'b1, "R6", "register holds 1 after preset falls");

        // R3: preset does not reach the pin in combinational mode.
        @(negedge clk);
        cfg_comb = 1'b1; cfg_pol_high = 1'b1; pterm = '0; preset_term = 1'b1;
        #1 check(pin_val, 1'b0, "R3", "comb pin ignores preset");
        @(posedge clk); #1;
        @(negedge clk) begin preset_term = 1'b0; cfg_comb = 1'b0; end
        #1 check(pin_val, 1'b1, "R6", "register still 1 after comb preset");

        // R7: reset clears at once and wins over preset.
        @(negedge clk) reset_term = 1'b1;
        #1 check(pin_val, 1'b0, "R7", "reset, active-high pin");
        cfg_pol_high = 1'b0;
        #0.2 check(pin_val, 1'b1, "R7", "reset, active-low pin");
        @(posedge clk); #1;
        @(negedge clk) preset_term = 1'b1;
        #1 check(pin_val, 1'b1, "R7", "reset wins over preset (active-low)");
        cfg_pol_high = 1'b1;
        #0.2 check(pin_val, 1'b0, "R7", "reset wins over preset (active-high)");
        @(posedge clk); #1;
        @(negedge clk) begin preset_term = 1'b0; reset_term = 1'b0; end

        // R8: preload ignores the terms, then normal capture resumes.
        @(negedge clk) begin pterm = '0; preload_en = 1'b1; preload_data = 1'b1; end
        @(posedge clk); #1;
        check(pin_val, 1'b1, "R8", "preload 1 with terms low");
        @(negedge clk) begin pterm = 8'hFF; preload_data = 1'b0; end
        @(posedge clk); #1;
        check(pin_val, 1'b0, "R8", "preload 0 with terms high");
        @(negedge clk) preload_en = 1'b0;
        @(posedge clk); #1;
        check(pin_val, 1'b1, "R8", "capture resumes after preload");

        // R1: synchronous clear wins over preload.
        @(negedge clk) begin rst_n = 1'b0; preload_en = 1'b1; preload_data = 1'b1; end
        @(posedge clk); #1;
        check(fb, 1'b0, "R1", "clear wins over preload");
        check(pin_val, 1'b0, "R1", "pin after clear");
        @(negedge clk) begin rst_n = 1'b1; preload_en = 1'b0; end

        // R10: combinational cell with enable low works as an input.
        @(negedge clk) begin cfg_comb = 1'b1; oe_term = 1'b0; ext_drive = 1'b1; end
        #1 check(fb, 1'b1, "R10", "input mode follows pin high");
        check(pin_oe, 1'b0, "R10", "input mode does not drive");
        ext_drive = 1'b0;
        #0.2 check(fb, 1'b0, "R10", "input mode follows pin low");

        @(negedge clk);
        finish_run();
    end

endmodule